// File: doc/BRIEF.md
# Multi-Buffer DRAM Bank Controller

This block controls a single bank of on-chip DRAM. The bank has three row-wide buffers that together act as a tiny row cache. Each buffer can hold one complete row of 64 words, and each word is 72 bits wide: 64 data bits plus 8 check bits. Two word ports share these buffers. The instruction-fetch port only reads. The load/store port reads and writes.

A request whose row is already held in a buffer is served in the cycle it is presented, and the array is not touched. A request whose row is not held in any buffer takes over the bank. The controller picks a buffer to replace. If that buffer holds modified data, it is first copied back to the array. The wanted row is then loaded into the buffer. Each array transfer takes a fixed number of cycles. After the load, the request is served as a hit.

The array itself sits outside the block. The block tells it which row to use and marks with a strobe the last cycle of each transfer. The bank number is a parameter, and it forms the upper bits of every row address sent to the array. Check bits are stored and returned unchanged; producing and checking them happens elsewhere.

Top module: `mdram_bank_ctrl`

## Requirements
- R1: After reset no buffer holds a row. Both ready outputs and both array strobes are low, and the first access to any row is a miss.
- R2: A request whose row is held in a buffer gets ready in the same cycle it is presented, with no array strobe.
- R3: A miss whose chosen buffer is unmodified asserts `arr_rd_stb` once, in the 6th cycle after the request is first presented (counting that cycle as 0). Ready follows in cycle 7. While the fill is in progress `arr_row` stays stable and neither ready output is high.
- R4: A miss whose chosen buffer holds modified data first copies that buffer back. `arr_wr_stb` is high in cycle 6 with the old row on `arr_row` and its contents on `arr_wdata`. `arr_rd_stb` is then high in cycle 12, and ready comes in cycle 13. The two strobes are never high together.
- R5: The buffer to replace is the lowest-numbered buffer that holds no row. If every buffer holds a row, it is the buffer used least recently, where both hits and fills count as uses.
- R6: When both ports request in the same cycle, the load/store port is served and `if_ready` stays low. A stalled port keeps its request, and it is served once the load/store request is gone.
- R7: A write that hits stores the whole 72-bit word, check bits included, and marks its buffer modified. Later reads return it unchanged, and this holds even after the row has been copied back and loaded again.
- R8: The column field selects word `col` of the row. That word sits at bits `[col*72 +: 72]` of the array row data, and columns 0 and 63 are both reachable.
- R9: On every array strobe, `arr_row[7:4]` equals the bank number parameter `BANK_ID`, and `arr_row[3:0]` is the row number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_req | input | 1 | Instruction port request, held until ready |
| if_row | input | 4 | Instruction port row number |
| if_col | input | 6 | Instruction port word within the row |
| if_ready | output | 1 | Instruction request served this cycle |
| if_rdata | output | 72 | Instruction word, valid with if_ready |
| dt_req | input | 1 | Load/store port request, held until ready |
| dt_we | input | 1 | Load/store port write enable |
| dt_row | input | 4 | Load/store port row number |
| dt_col | input | 6 | Load/store port word within the row |
| dt_wdata | input | 72 | Word to write |
| dt_ready | output | 1 | Load/store request served this cycle |
| dt_rdata | output | 72 | Word read, valid with dt_ready |
| arr_row | output | 8 | Bank number and row number for the array |
| arr_rd_stb | output | 1 | Last cycle of a row load; arr_rdata is sampled |
| arr_wr_stb | output | 1 | Last cycle of a row copy-back; array stores arr_wdata |
| arr_wdata | output | 4608 | Row contents being copied back |
| arr_rdata | input | 4608 | Row contents from the array |

## Verification
If the tag, valid or modified state is wrong, it shows up at the ports on the very next access to that row. A hit that should be a miss answers in cycle 0 with the wrong word. A miss that should be a hit takes 7 or 13 cycles. A buffer whose modified flag was lost never raises the copy-back strobe, so the written word is missing after the row is loaded again.

A wrong least-recently-used order takes longer to show. It only changes which row is evicted, and the error becomes visible several accesses later, as an unexpected 7-cycle or 13-cycle latency on a row that should still be held. The access sequence is therefore built so that every eviction decision is followed by an access that depends on it.

// File: rtl/bank_pkg.sv
package bank_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WBACK = 2'd1,
    SQ_FILL  = 2'd2
  } seq_st_e;

  // bit offset of a word inside a row line
  function automatic int unsigned word_lsb(input int unsigned col, input int unsigned dw);
    return col * dw;
  endfunction
endpackage

// File: rtl/bank_rowbuf_store.sv
module bank_rowbuf_store #(
  parameter int NUM_BUF = 3,
  parameter int WORDS   = 64,
  parameter int DW      = 72,
  localparam int BUF_W  = $clog2(NUM_BUF),
  localparam int COL_W  = $clog2(WORDS),
  localparam int LINE_W = WORDS * DW
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic [BUF_W-1:0]  ld_idx,
  input  logic [LINE_W-1:0] ld_line,
  input  logic              wr_en,
  input  logic [BUF_W-1:0]  wr_idx,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DW-1:0]     wr_word,
  input  logic [BUF_W-1:0]  rd_idx,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DW-1:0]     rd_word,
  input  logic [BUF_W-1:0]  ln_idx,
  output logic [LINE_W-1:0] ln_line
);
  logic [DW-1:0] words_q [NUM_BUF][WORDS];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BUF; b++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (ld_en && ld_idx == BUF_W'(b))
          words_q[b][w] <= ld_line[bank_pkg::word_lsb(w, DW) +: DW];
        else if (wr_en && wr_idx == BUF_W'(b) && wr_col == COL_W'(w))
          words_q[b][w] <= wr_word;
      end
    end
  end

  assign rd_word = words_q[rd_idx][rd_col];

  always_comb begin
    ln_line = '0;
    for (int w = 0; w < WORDS; w++)
      ln_line[bank_pkg::word_lsb(w, DW) +: DW] = words_q[ln_idx][w];
  end
endmodule

// File: rtl/bank_tag_dir.sv
module bank_tag_dir #(
  parameter int NUM_BUF = 3,
  parameter int ROW_W   = 4,
  localparam int BUF_W  = $clog2(NUM_BUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] lk_row,
  output logic             hit,
  output logic [BUF_W-1:0] hit_idx,
  output logic [BUF_W-1:0] vic_idx,
  output logic             vic_needs_wb,
  output logic [ROW_W-1:0] vic_tag,
  input  logic             touch_en,
  input  logic [BUF_W-1:0] touch_idx,
  input  logic             fill_en,
  input  logic [BUF_W-1:0] fill_idx,
  input  logic [ROW_W-1:0] fill_row,
  input  logic             dirty_en,
  input  logic [BUF_W-1:0] dirty_idx
);
  logic [NUM_BUF-1:0] valid_q, dirty_q, match;
  logic [ROW_W-1:0]   tag_q [NUM_BUF];
  logic [BUF_W-1:0]   age_q [NUM_BUF];
  logic [BUF_W-1:0]   touched_age;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_row);
  end

  assign hit = |match;
  assign touched_age = age_q[touch_idx];

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--)
      if (match[i]) hit_idx = BUF_W'(i);
  end

  // empty buffer first (lowest index), else the oldest one
  always_comb begin
    vic_idx = '0;
    for (int i = 0; i < NUM_BUF; i++)
      if (age_q[i] == BUF_W'(NUM_BUF - 1)) vic_idx = BUF_W'(i);
    for (int i = NUM_BUF - 1; i >= 0; i--)
      if (!valid_q[i]) vic_idx = BUF_W'(i);
  end

  assign vic_needs_wb = valid_q[vic_idx] && dirty_q[vic_idx];
  assign vic_tag      = tag_q[vic_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < NUM_BUF; i++) begin
        tag_q[i] <= '0;
        age_q[i] <= BUF_W'(i);
      end
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (fill_en && fill_idx == BUF_W'(i)) begin
          valid_q[i] <= 1'b1;
          dirty_q[i] <= 1'b0;
          tag_q[i]   <= fill_row;
        end else if (dirty_en && dirty_idx == BUF_W'(i)) begin
          dirty_q[i] <= 1'b1;
        end
        if (touch_en) begin
          if (touch_idx == BUF_W'(i))
            age_q[i] <= '0;
          else if (age_q[i] < touched_age)
            age_q[i] <= age_q[i] + BUF_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bank_seq.sv
module bank_seq #(
  parameter int LAT = 6,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wb,
  output logic in_wb,
  output logic in_fill,
  output logic wb_last,
  output logic fill_last
);
  import bank_pkg::*;

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end    = (cnt_q == CW'(LAT - 1));
  assign in_wb     = (st_q == SQ_WBACK);
  assign in_fill   = (st_q == SQ_FILL);
  assign wb_last   = in_wb && at_end;
  assign fill_last = in_fill && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (start) begin
          st_q  <= start_wb ? SQ_WBACK : SQ_FILL;
          cnt_q <= '0;
        end
        SQ_WBACK: if (at_end) begin
          st_q  <= SQ_FILL;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + CW'(1);
        SQ_FILL: if (at_end) begin
          st_q  <= SQ_IDLE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + CW'(1);
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdram_bank_ctrl.sv
module mdram_bank_ctrl #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_ID   = 5,
  parameter int NUM_ROWS  = 16,
  parameter int NUM_BUF   = 3,
  parameter int WORDS     = 64,
  parameter int DW        = 72,
  parameter int LAT       = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int COL_W    = $clog2(WORDS),
  localparam int BUF_W    = $clog2(NUM_BUF),
  localparam int LINE_W   = WORDS * DW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    if_req,
  input  logic [ROW_W-1:0]        if_row,
  input  logic [COL_W-1:0]        if_col,
  output logic                    if_ready,
  output logic [DW-1:0]           if_rdata,
  input  logic                    dt_req,
  input  logic                    dt_we,
  input  logic [ROW_W-1:0]        dt_row,
  input  logic [COL_W-1:0]        dt_col,
  input  logic [DW-1:0]           dt_wdata,
  output logic                    dt_ready,
  output logic [DW-1:0]           dt_rdata,
  output logic [BANK_W+ROW_W-1:0] arr_row,
  output logic                    arr_rd_stb,
  output logic                    arr_wr_stb,
  output logic [LINE_W-1:0]       arr_wdata,
  input  logic [LINE_W-1:0]       arr_rdata
);
  // named internal events
  logic             busy, idle, any_req, miss_start, grant_dt, grant_if;
  logic             in_wb, in_fill, wb_done, fill_done;
  logic [ROW_W-1:0] lk_row;
  logic [COL_W-1:0] lk_col;
  logic             hit, vic_needs_wb;
  logic [BUF_W-1:0] hit_idx, vic_idx, tgt_idx_q, touch_idx;
  logic [ROW_W-1:0] vic_tag, tgt_row_q, wb_row_q;
  logic [DW-1:0]    rd_word;

  assign busy       = in_wb || in_fill;
  assign idle       = !busy;
  assign any_req    = dt_req || if_req;
  assign grant_dt   = idle && dt_req;
  assign grant_if   = idle && if_req && !dt_req;
  assign lk_row     = dt_req ? dt_row : if_row;
  assign lk_col     = dt_req ? dt_col : if_col;
  assign miss_start = idle && any_req && !hit;

  assign dt_ready = grant_dt && hit;
  assign if_ready = grant_if && hit;
  assign dt_rdata = rd_word;
  assign if_rdata = rd_word;
  assign touch_idx = fill_done ? tgt_idx_q : hit_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_idx_q <= '0;
      tgt_row_q <= '0;
      wb_row_q  <= '0;
    end else if (miss_start) begin
      tgt_idx_q <= vic_idx;
      tgt_row_q <= lk_row;
      wb_row_q  <= vic_tag;
    end
  end

  assign arr_row    = {BANK_W'(BANK_ID), (in_wb ? wb_row_q : tgt_row_q)};
  assign arr_rd_stb = fill_done;
  assign arr_wr_stb = wb_done;

  bank_seq #(.LAT(LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (miss_start),
    .start_wb  (vic_needs_wb),
    .in_wb     (in_wb),
    .in_fill   (in_fill),
    .wb_last   (wb_done),
    .fill_last (fill_done)
  );

  bank_tag_dir #(.NUM_BUF(NUM_BUF), .ROW_W(ROW_W)) u_dir (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_row       (lk_row),
    .hit          (hit),
    .hit_idx      (hit_idx),
    .vic_idx      (vic_idx),
    .vic_needs_wb (vic_needs_wb),
    .vic_tag      (vic_tag),
    .touch_en     (dt_ready || if_ready || fill_done),
    .touch_idx    (touch_idx),
    .fill_en      (fill_done),
    .fill_idx     (tgt_idx_q),
    .fill_row     (tgt_row_q),
    .dirty_en     (dt_ready && dt_we),
    .dirty_idx    (hit_idx)
  );

  bank_rowbuf_store #(.NUM_BUF(NUM_BUF), .WORDS(WORDS), .DW(DW)) u_store (
    .clk     (clk),
    .ld_en   (fill_done),
    .ld_idx  (tgt_idx_q),
    .ld_line (arr_rdata),
    .wr_en   (dt_ready && dt_we),
    .wr_idx  (hit_idx),
    .wr_col  (dt_col),
    .wr_word (dt_wdata),
    .rd_idx  (hit_idx),
    .rd_col  (lk_col),
    .rd_word (rd_word),
    .ln_idx  (tgt_idx_q),
    .ln_line (arr_wdata)
  );
endmodule

// File: rtl/bank_ctrl_chk.sv
module bank_ctrl_chk #(
  parameter int BANK_ID = 5,
  parameter int BANK_W  = 4,
  parameter int ROW_W   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    if_ready,
  input logic                    dt_req,
  input logic                    dt_ready,
  input logic                    arr_rd_stb,
  input logic                    arr_wr_stb,
  input logic [BANK_W+ROW_W-1:0] arr_row,
  input logic                    in_wb,
  input logic                    in_fill
);
  AST_READY_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wb || in_fill) |-> !(if_ready || dt_ready)); // R3
  AST_FILL_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fill && $past(in_fill)) |-> $stable(arr_row)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_rd_stb && arr_wr_stb)); // R4
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_wb) |-> in_fill); // R4
  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    dt_req |-> !if_ready); // R6
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({if_ready, dt_ready}) <= 1); // R6
  AST_HIT_NO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (if_ready || dt_ready) |-> !(arr_rd_stb || arr_wr_stb)); // R2
  AST_BANK_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd_stb || arr_wr_stb) |-> (arr_row[BANK_W+ROW_W-1 -: BANK_W] == BANK_W'(BANK_ID))); // R9
endmodule

bind mdram_bank_ctrl bank_ctrl_chk #(
  .BANK_ID (BANK_ID),
  .BANK_W  (BANK_W),
  .ROW_W   (ROW_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .if_ready   (if_ready),
  .dt_req     (dt_req),
  .dt_ready   (dt_ready),
  .arr_rd_stb (arr_rd_stb),
  .arr_wr_stb (arr_wr_stb),
  .arr_row    (arr_row),
  .in_wb      (in_wb),
  .in_fill    (in_fill)
);

// File: tb/sim_mdram_bank_ctrl.sv
`timescale 1ns/1ps
module sim_mdram_bank_ctrl;
  localparam int BANK_ID = 5;
  localparam int NROWS   = 16;
  localparam int NW      = 64;
  localparam int DW      = 72;
  localparam int LINE_W  = NW * DW;
  localparam logic [71:0] WX = 72'h5A_1234_5678_9ABC_DEF0;
  localparam logic [71:0] WY = 72'hFF_0000_0000_0000_0001;

  // {port(1=load/store), we, row[4], col[6], latency[8], wdata[72]}
  localparam logic [91:0] VEC [15] = '{
    {1'b1, 1'b0, 4'd3,  6'd5,  8'd7,  72'h0},
    {1'b0, 1'b0, 4'd3,  6'd7,  8'd0,  72'h0},
    {1'b1, 1'b1, 4'd3,  6'd7,  8'd0,  WX},
    {1'b0, 1'b0, 4'd9,  6'd0,  8'd7,  72'h0},
    {1'b1, 1'b0, 4'd12, 6'd63, 8'd7,  72'h0},
    {1'b1, 1'b0, 4'd3,  6'd7,  8'd0,  72'h0},
    {1'b1, 1'b0, 4'd5,  6'd1,  8'd7,  72'h0},
    {1'b1, 1'b1, 4'd12, 6'd0,  8'd0,  WY},
    {1'b0, 1'b0, 4'd9,  6'd4,  8'd13, 72'h0},
    {1'b0, 1'b0, 4'd3,  6'd7,  8'd7,  72'h0},
    {1'b1, 1'b0, 4'd12, 6'd0,  8'd0,  72'h0},
    {1'b1, 1'b0, 4'd15, 6'd2,  8'd7,  72'h0},
    {1'b1, 1'b0, 4'd0,  6'd0,  8'd7,  72'h0},
    {1'b1, 1'b0, 4'd1,  6'd9,  8'd13, 72'h0},
    {1'b1, 1'b0, 4'd12, 6'd0,  8'd7,  72'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_req = 1'b0, dt_req = 1'b0, dt_we = 1'b0;
  logic [3:0] if_row = '0, dt_row = '0;
  logic [5:0] if_col = '0, dt_col = '0;
  logic [71:0] dt_wdata = '0;
  logic if_ready, dt_ready, arr_rd_stb, arr_wr_stb;
  logic [71:0] if_rdata, dt_rdata;
  logic [7:0] arr_row;
  logic [LINE_W-1:0] arr_wdata, arr_rdata;
  logic [LINE_W-1:0] mem [NROWS];
  logic [71:0] shadow [NROWS][NW];
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mdram_bank_ctrl #(.BANK_ID(BANK_ID)) u0 (
    .clk(clk), .rst_n(rst_n),
    .if_req(if_req), .if_row(if_row), .if_col(if_col), .if_ready(if_ready), .if_rdata(if_rdata),
    .dt_req(dt_req), .dt_we(dt_we), .dt_row(dt_row), .dt_col(dt_col), .dt_wdata(dt_wdata),
    .dt_ready(dt_ready), .dt_rdata(dt_rdata),
    .arr_row(arr_row), .arr_rd_stb(arr_rd_stb), .arr_wr_stb(arr_wr_stb),
    .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
  );

  function automatic logic [71:0] pat(input int r, input int c);
    return {8'(r * 16 + c), 32'hA500_0000 | 32'(r), 32'h00C0_0000 | 32'(c)};
  endfunction

  assign arr_rdata = mem[arr_row[3:0]];
  always @(posedge clk) if (arr_wr_stb) mem[arr_row[3:0]] <= arr_wdata;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_access(input logic port, input logic we, input logic [3:0] row,
                           input logic [5:0] col, input logic [71:0] wd, input int exp_lat);
    int lat = 0, nrd = 0, nwr = 0;
    bit bank_ok = 1'b1;
    logic got;
    logic [71:0] rd;
    string lreq;
    @(negedge clk);
    if (port) begin
      dt_req = 1'b1; dt_we = we; dt_row = row; dt_col = col; dt_wdata = wd;
    end else begin
      if_req = 1'b1; if_row = row; if_col = col;
    end
    forever begin
      #1;
      if (arr_rd_stb) nrd++;
      if (arr_wr_stb) nwr++;
      if ((arr_rd_stb || arr_wr_stb) && arr_row[7:4] != 4'(BANK_ID)) bank_ok = 1'b0;
      got = port ? dt_ready : if_ready;
      rd  = port ? dt_rdata : if_rdata;
      if (got || lat > 200) break;
      @(negedge clk);
      lat++;
    end
    lreq = (exp_lat == 0) ? "R2" : (exp_lat == 7) ? "R3/R5" : "R4/R5";
    check(lat == exp_lat, lreq, "latency", 72'(lat), 72'(exp_lat));
    check(nrd == (exp_lat > 0 ? 1 : 0), lreq, "row load strobes", 72'(nrd), 72'(exp_lat > 0));
    check(nwr == (exp_lat == 13 ? 1 : 0), "R4", "copy-back strobes", 72'(nwr), 72'(exp_lat == 13));
    check(bank_ok, "R9", "bank field on arr_row", 72'(arr_row), 72'(BANK_ID));
    if (!we) check(rd === shadow[row][col], "R7/R8", "read word", rd, shadow[row][col]);
    if (we) shadow[row][col] = wd;
    @(negedge clk);
    if_req = 1'b0; dt_req = 1'b0; dt_we = 1'b0;
  endtask

  initial begin
    for (int r = 0; r < NROWS; r++)
      for (int c = 0; c < NW; c++) begin
        mem[r][c*DW +: DW] = pat(r, c);
        shadow[r][c] = pat(r, c);
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: idle outputs after reset
    check(!if_ready && !dt_ready, "R1", "ready after reset", {70'b0, if_ready, dt_ready}, 72'h0);
    check(!arr_rd_stb && !arr_wr_stb, "R1", "strobes after reset", {70'b0, arr_rd_stb, arr_wr_stb}, 72'h0);

    // vector walk: R1 first miss, R2..R5, R7, R8, R9
    for (int i = 0; i < 15; i++)
      do_access(VEC[i][91], VEC[i][90], VEC[i][89:86], VEC[i][85:80], VEC[i][71:0], int'(VEC[i][79:72]));

    // R6: both ports hit in the same cycle (rows 0 and 1 are held)
    @(negedge clk);
    dt_req = 1'b1; dt_row = 4'd0; dt_col = 6'd0;
    if_req = 1'b1; if_row = 4'd1; if_col = 6'd9;
    #1;
    check(dt_ready && !if_ready, "R6", "load/store wins", {70'b0, dt_ready, if_ready}, 72'h2);
    check(dt_rdata === shadow[0][0], "R6", "load/store word", dt_rdata, shadow[0][0]);
    @(negedge clk);
    dt_req = 1'b0;
    #1;
    check(if_ready === 1'b1, "R6", "instruction served next", 72'(if_ready), 72'h1);
    check(if_rdata === shadow[1][9], "R6", "instruction word", if_rdata, shadow[1][9]);
    @(negedge clk);
    if_req = 1'b0;

    // R6: load/store miss while instruction waits on a held row
    begin
      int lat = 0;
      bit if_seen = 1'b0;
      @(negedge clk);
      dt_req = 1'b1; dt_row = 4'd7; dt_col = 6'd3;
      if_req = 1'b1; if_row = 4'd1; if_col = 6'd9;
      forever begin
        #1;
        if (if_ready) if_seen = 1'b1;
        if (dt_ready || lat > 200) break;
        @(negedge clk);
        lat++;
      end
      check(lat == 7, "R6", "load/store miss latency with both pending", 72'(lat), 72'd7);
      check(!if_seen, "R6", "instruction held off", 72'(if_seen), 72'h0);
      check(dt_rdata === shadow[7][3], "R8", "word 3 of row 7", dt_rdata, shadow[7][3]);
      @(negedge clk);
      dt_req = 1'b0;
      #1;
      check(if_ready === 1'b1, "R6", "instruction after release", 72'(if_ready), 72'h1);
      @(negedge clk);
      if_req = 1'b0;
    end

    // R1: reset in mid-run empties all buffers
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_access(1'b1, 1'b0, 4'd12, 6'd0, 72'h0, 7);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule